// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This unit holds the pending-interrupt state of a byte-wide peripheral with seven interrupt sources. Each source raises its pending bit with a one-cycle set pulse. The pending bit is latched even while that source is masked, so software can poll it. A bit is released in either of two ways:

- the CPU writes ones to it through the bus;
- the peripheral logic pulses the matching clear strobe as a side effect of some other access.

A separate mask register selects which pending bits may interrupt the CPU. Software changes the mask with a single write. Data bit 7 of that write picks between setting and clearing the bits named in data bits 6..0.

The pending register reads back with a derived bit 7. That bit is 1 whenever some pending bit is also unmasked, and it drives the active-low interrupt line. The register offsets are fixed at 13 (pending) and 14 (mask) because the surrounding register decoder relies on them. The sources themselves, their edge detection and any prioritising are outside this unit.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset every pending bit and every mask bit is 0. Reading offset 13 returns 0x00, reading offset 14 returns 0x80, and irq_n is 1.
- R2: A 1 on set_pulse[i] latches pending bit i at the next clock edge, whether or not mask bit i is set. Bit 6 is the first timer, bit 5 the second timer, and bits 4..0 the control-line and shift sources. A pending bit never rises without its pulse.
- R3: A bus write to offset 13 clears each pending bit whose data bit (6..0) is 1 and leaves the others unchanged. Data bit 7 of that write has no effect.
- R4: A 1 on clr_strobe[i] clears pending bit i at the next clock edge.
- R5: When a set pulse and any clear (bus write or strobe) hit the same bit in the same cycle, the bit ends up set.
- R6: A bus write to offset 14 with data bit 7 = 1 sets each mask bit whose data bit (6..0) is 1. Mask bits whose data bit is 0 keep their value.
- R7: A bus write to offset 14 with data bit 7 = 0 clears each mask bit whose data bit (6..0) is 1. Mask bits whose data bit is 0 keep their value.
- R8: Reading offset 14 returns the seven mask bits in bits 6..0, with bit 7 always 1.
- R9: Reading offset 13 returns the pending bits in 6..0. Bit 7 is 1 exactly when pending AND mask is non-zero. irq_n is the inverse of that bit, and both follow any change of either register in the cycle after the change.
- R10: Reads of any other offset return 0x00, and writes to any other offset change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 4 | Register offset for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| set_pulse | input | 7 | Per-source set pulses |
| clr_strobe | input | 7 | Per-source clear strobes from peripheral side effects |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A corrupted pending or mask bit shows up at the ports in the cycle after the edge that stored it. It appears on the readback of offset 13 or 14, and on irq_n whenever the bad bit is paired with a set bit in the other register. The bench therefore reads both registers and irq_n after every clock. This also exposes a clear that hits the wrong bit, a set that loses to a clear, or a mask write with an inverted mode in the same cycle as the fault. Random traffic mixes pulses, strobes and writes to all offsets. Directed cases cover the same-cycle set/clear collision and the ignored data bit 7 on pending writes.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int DATA_W = 8;
  localparam int NSRC   = DATA_W - 1;
  localparam int MODE_BIT = DATA_W - 1;
  typedef logic [NSRC-1:0]   src_vec_t;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    logic upd_en;
    logic flag_d;
    // set has priority over every kind of clear
    always_comb begin
      upd_en = set_vec[i] | clr_vec[i];
      flag_d = set_vec[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else if (upd_en) begin
        flag_q[i] <= flag_d;
      end
    end
  end
endmodule

// File: rtl/irqf_enable_bank.sv
module irqf_enable_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         mode_set,
  input  logic [N-1:0] sel,
  output logic [N-1:0] en_q
);
  logic [N-1:0] en_d;
  logic         upd_en;

  always_comb begin
    upd_en = wr_en & (|sel);
    if (mode_set) en_d = en_q | sel;
    else          en_d = en_q & ~sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (upd_en) begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/irqf_read_mux.sv
module irqf_read_mux #(
  parameter int N = 7
) (
  input  logic         pick_flag,
  input  logic         pick_en,
  input  logic         summary,
  input  logic [N-1:0] flag_q,
  input  logic [N-1:0] en_q,
  output logic [N:0]   rdata
);
  always_comb begin
    if (pick_flag)    rdata = {summary, flag_q};
    else if (pick_en) rdata = {1'b1, en_q};
    else              rdata = '0;
  end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irqf_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int FLAG_OFS = 13,
  parameter int MASK_OFS = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   set_pulse,
  input  logic [NSRC-1:0]   clr_strobe,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_OFS);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

  logic     hit_flag, hit_mask;
  src_vec_t cpu_clr, all_clr;
  src_vec_t flag_vec, mask_vec;
  logic     summary;

  always_comb begin
    hit_flag = (bus_addr == FLAG_A);
    hit_mask = (bus_addr == MASK_A);
    cpu_clr  = (bus_wr && hit_flag) ? bus_wdata[NSRC-1:0] : '0;
    all_clr  = cpu_clr | clr_strobe;
  end

  irqf_flag_bank #(.N(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_pulse),
    .clr_vec (all_clr),
    .flag_q  (flag_vec)
  );

  irqf_enable_bank #(.N(NSRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr & hit_mask),
    .mode_set (bus_wdata[MODE_BIT]),
    .sel      (bus_wdata[NSRC-1:0]),
    .en_q     (mask_vec)
  );

  always_comb begin
    summary = |(flag_vec & mask_vec);
    irq_n   = ~summary;
  end

  irqf_read_mux #(.N(NSRC)) u_rd (
    .pick_flag (hit_flag),
    .pick_en   (hit_mask),
    .summary   (summary),
    .flag_q    (flag_vec),
    .en_q      (mask_vec),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker #(
  parameter int ADDR_W   = 4,
  parameter int FLAG_OFS = 13,
  parameter int MASK_OFS = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [6:0]        set_pulse,
  input logic [6:0]        clr_strobe,
  input logic              irq_n,
  input logic [6:0]        flag_q,
  input logic [6:0]        en_q
);
  logic wr_flag, wr_mask;
  assign wr_flag = bus_wr && (bus_addr == ADDR_W'(FLAG_OFS));
  assign wr_mask = bus_wr && (bus_addr == ADDR_W'(MASK_OFS));

  AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse != 7'd0) |=> ((flag_q & $past(set_pulse)) == $past(set_pulse))); // R5

  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_pulse)) == 7'd0)); // R2

  AST_CPU_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && ((bus_wdata[6:0] & set_pulse) == 7'd0))
      |=> ((flag_q & $past(bus_wdata[6:0])) == 7'd0)); // R3

  AST_STROBE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_strobe & ~set_pulse) != 7'd0)
      |=> ((flag_q & $past(clr_strobe & ~set_pulse)) == 7'd0)); // R4

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && bus_wdata[7])
      |=> ((en_q & $past(bus_wdata[6:0])) == $past(bus_wdata[6:0]))); // R6

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !bus_wdata[7])
      |=> ((en_q & $past(bus_wdata[6:0])) == 7'd0)); // R7

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mask) |=> $stable(en_q)); // R10

  AST_IRQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ((flag_q & en_q) == 7'd0)); // R9
endmodule

bind irq_flag_unit irqf_checker #(
  .ADDR_W   (ADDR_W),
  .FLAG_OFS (FLAG_OFS),
  .MASK_OFS (MASK_OFS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .set_pulse  (set_pulse),
  .clr_strobe (clr_strobe),
  .irq_n      (irq_n),
  .flag_q     (flag_vec),
  .en_q       (mask_vec)
);

// File: tb/tb_irq_flag_unit.sv
module tb_irq_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [6:0] set_pulse;
  logic [6:0] clr_strobe;
  logic       irq_n;

  int n_chk = 0;
  int n_fail = 0;
  logic [6:0] m_flag, m_mask;

  always #4 clk = ~clk;

  irq_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .set_pulse(set_pulse),
    .clr_strobe(clr_strobe), .irq_n(irq_n)
  );

  function automatic logic [7:0] exp_flag_rd(logic [6:0] f, logic [6:0] m);
    return {|(f & m), f};
  endfunction

  function automatic logic [7:0] exp_mask_rd(logic [6:0] m);
    return {1'b1, m};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bus_wr = 1'b0; bus_addr = 4'd0; bus_wdata = 8'h00;
    set_pulse = 7'h00; clr_strobe = 7'h00;
  endtask

  // read both registers, irq line and an unmapped offset
  task automatic observe(string tag);
    bus_addr = 4'd13; #1;
    chk({tag, " R9 flag read"}, bus_rdata, exp_flag_rd(m_flag, m_mask));
    bus_addr = 4'd14; #1;
    chk({tag, " R8 mask read"}, bus_rdata, exp_mask_rd(m_mask));
    chk({tag, " R9 irq_n"}, {7'd0, irq_n}, {7'd0, ~(|(m_flag & m_mask))});
    bus_addr = 4'd3; #1;
    chk({tag, " R10 other read"}, bus_rdata, 8'h00);
  endtask

  task automatic step(logic we, logic [3:0] a, logic [7:0] d,
                      logic [6:0] s, logic [6:0] c, string tag);
    bus_wr = we; bus_addr = a; bus_wdata = d; set_pulse = s; clr_strobe = c;
    @(posedge clk);
    if (we && a == 4'd13) m_flag = m_flag & ~d[6:0];
    m_flag = (m_flag & ~c) | s;
    if (we && a == 4'd14) m_mask = d[7] ? (m_mask | d[6:0]) : (m_mask & ~d[6:0]);
    #1;
    idle_inputs();
    observe(tag);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd24681);
    idle_inputs();
    m_flag = '0; m_mask = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    bus_addr = 4'd13; #1; chk("R1 flag after reset", bus_rdata, 8'h00);
    bus_addr = 4'd14; #1; chk("R1 mask after reset", bus_rdata, 8'h80);
    chk("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);

    step(1'b0, 4'd0, 8'h00, 7'h40, 7'h00, "R2 timer1 set while masked");
    step(1'b1, 4'd14, 8'hC0, 7'h00, 7'h00, "R6 enable bit6");
    step(1'b1, 4'd13, 8'h80, 7'h00, 7'h00, "R3 data bit7 ignored");
    step(1'b0, 4'd0, 8'h00, 7'h20, 7'h20, "R5 set beats strobe");
    step(1'b1, 4'd13, 8'h20, 7'h20, 7'h00, "R5 set beats cpu clear");
    step(1'b0, 4'd0, 8'h00, 7'h00, 7'h40, "R4 strobe clears bit6");
    step(1'b1, 4'd14, 8'hA0, 7'h00, 7'h00, "R6 enable bit5");
    step(1'b1, 4'd14, 8'h40, 7'h00, 7'h00, "R7 clear bit6 keeps bit5");
    step(1'b1, 4'd3, 8'hFF, 7'h00, 7'h00, "R10 write other offset");
    step(1'b1, 4'd14, 8'h00, 7'h00, 7'h00, "R7 zero data no change");
    step(1'b0, 4'd0, 8'h00, 7'h1F, 7'h00, "R2 low sources");
    step(1'b1, 4'd13, 8'h7F, 7'h00, 7'h00, "R3 clear all");

    for (int k = 0; k < 400; k++) begin
      logic [2:0] op;
      logic [3:0] a;
      op = 3'($urandom_range(0, 7));
      a = (op < 3) ? 4'd13 : (op < 6) ? 4'd14 : 4'($urandom_range(0, 15));
      step(1'($urandom_range(0, 1)), a, 8'($urandom),
           7'($urandom) & 7'($urandom), 7'($urandom) & 7'($urandom),
           "R2 R3 R4 R5 R6 R7 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule